// File: doc/BRIEF.md
# Frame head word selector

This block sits on a streaming path and shortens every frame to a fixed number of leading words. Each word arrives on a sink with valid, ready, start-of-frame and end-of-frame flags. The first `KEEP_WORDS` words of a frame go out on a source with the same signals, as a new frame with freshly generated start and end flags. The remaining words of that input frame are accepted and thrown away, up to and including the input end-of-frame. If a frame is shorter than `KEEP_WORDS`, all of it is forwarded and the input end-of-frame ends the output frame.

One output register sits between the sink and the source, so a forwarded word appears exactly one clock after it is accepted. Backpressure reaches the sink only while words are being forwarded. In the discard phase the sink is always ready. A gapless input stream with an always-ready sink therefore passes through without a single stall cycle, including across frame boundaries.

The input word can be taken from a plain data port or built from separate real and imaginary halves. A parameter selects which.

Top module: `frame_head_sel`

## Requirements
- R1: Input words with index 0 to KEEP_WORDS-1 in a frame (index 0 being the word flagged start-of-frame) appear on the output in order with unchanged data.
- R2: Input words with index KEEP_WORDS or higher are consumed and never appear on the output.
- R3: The output start-of-frame flag is 1 exactly on the forwarded word of index 0, so every output word after an output end-of-frame carries start-of-frame.
- R4: The output end-of-frame flag is 1 on the word of index KEEP_WORDS-1, or on an input end-of-frame word of lower index, and 0 otherwise.
- R5: A forwarded word accepted on one clock edge is presented with outValid high after the very next edge.
- R6: In the discard phase (KEEP_WORDS words of the frame already taken, current word not start-of-frame), inReady is 1 whatever outReady is.
- R7: inReady is 1 whenever the output register is empty or outReady is 1. A continuously valid input with outReady held at 1 is accepted on every cycle, across frame boundaries.
- R8: While outValid is 1 and outReady is 0, outValid stays 1 and outData, outSop and outEop keep their values.
- R9: With COMPLEX_IN=1 the word is {inRe, inIm}, with the real half in the upper DATA_W/2 bits. With COMPLEX_IN=0 it is inData.
- R10: A synchronous reset clears outValid and the frame word counter, after which inReady is 1.
- R11: With KEEP_WORDS=1 each frame yields one output word carrying both start-of-frame and end-of-frame, and all later words of the frame are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | DATA_W | Plain input word (used when COMPLEX_IN=0) |
| inRe | input | DATA_W/2 | Real half of a complex word (used when COMPLEX_IN=1) |
| inIm | input | DATA_W/2 | Imaginary half of a complex word (used when COMPLEX_IN=1) |
| inValid | input | 1 | Input word valid |
| inSop | input | 1 | Input word is the first of its frame |
| inEop | input | 1 | Input word is the last of its frame |
| inReady | output | 1 | Block accepts the input word this cycle |
| outData | output | DATA_W | Forwarded word |
| outValid | output | 1 | Output word valid |
| outSop | output | 1 | Output word starts a shortened frame |
| outEop | output | 1 | Output word ends a shortened frame |
| outReady | input | 1 | Downstream accepts the output word |

## Verification
On every cycle the assertions check the following: the one-cycle latency from a forwarded acceptance to outValid, that a stalled output word holds still, that an empty output register never blocks the sink, that the word counter stays bounded and restarts after an end-of-frame, and that an output end-of-frame is always followed by a start-of-frame. Other properties are visible only in the bench's scenarios, where a reference model sees the whole frame. These are which words are forwarded and which are dropped, where end-of-frame falls for short and long frames, the no-stall behaviour of a gapless stream, sink readiness during discard under output stall, and the packing of complex halves with KEEP_WORDS=1.

// File: rtl/hsel_pkg.sv
package hsel_pkg;

  // Strobes from the frame control to the output register
  typedef struct packed {
    logic load;   // capture the current input word
    logic first;  // word index 0 of its frame
    logic last;   // word closes the shortened frame
  } hselStrobe_t;

endpackage

// File: rtl/hsel_word_pack.sv
module hsel_word_pack #(
  parameter int DATA_W     = 16,
  parameter bit COMPLEX_IN = 1'b0
) (
  input  logic [DATA_W-1:0]   plainData,
  input  logic [DATA_W/2-1:0] reData,
  input  logic [DATA_W/2-1:0] imData,
  output logic [DATA_W-1:0]   word
);

  generate
    if (COMPLEX_IN) begin : g_complex
      // real half on top, imaginary half below
      logic unusedPlain;
      assign unusedPlain = ^plainData;
      assign word = {reData, imData};
    end else begin : g_plain
      logic unusedHalves;
      assign unusedHalves = ^{reData, imData};
      assign word = plainData;
    end
  endgenerate

endmodule

// File: rtl/hsel_ctrl.sv
module hsel_ctrl
  import hsel_pkg::*;
#(
  parameter int KEEP_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inSop,
  input  logic        inEop,
  input  logic        slotFree,
  output logic        inReady,
  output hselStrobe_t strobe
);

  localparam int CNT_W = $clog2(KEEP_WORDS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(KEEP_WORDS);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(KEEP_WORDS - 1);

  logic [CNT_W-1:0] wordCnt;
  logic [CNT_W-1:0] wordIdx;
  logic [CNT_W-1:0] nextCnt;
  logic             discarding;
  logic             forwardWord;
  logic             accept;

  // a start-of-frame word always restarts the index
  assign wordIdx     = inSop ? '0 : wordCnt;
  assign forwardWord = (wordIdx < LIMIT);
  assign discarding  = (wordCnt == LIMIT) && !inSop;

  // discard phase ignores the downstream side entirely
  assign inReady = discarding || slotFree;
  assign accept  = inValid && inReady;

  assign strobe.load  = accept && forwardWord;
  assign strobe.first = (wordIdx == '0);
  assign strobe.last  = (wordIdx == LAST) || inEop;

  always_comb begin
    nextCnt = wordCnt;
    if (accept) begin
      if (inEop)                nextCnt = '0;
      else if (wordIdx == LIMIT) nextCnt = LIMIT;
      else                       nextCnt = wordIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wordCnt <= '0;
    else     wordCnt <= nextCnt;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wordCnt <= LIMIT);

  // R4
  eop_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inEop) |=> (wordCnt == '0));

endmodule

// File: rtl/hsel_datapath.sv
module hsel_datapath
  import hsel_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  hselStrobe_t       strobe,
  input  logic [DATA_W-1:0] word,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic              slotFree
);

  assign slotFree = !outValid || outReady;

  always_ff @(posedge clk) begin
    if (rst)              outValid <= 1'b0;
    else if (strobe.load) outValid <= 1'b1;
    else if (outReady)    outValid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      outData <= word;
      outSop  <= strobe.first;
      outEop  <= strobe.last;
    end
  end

  // R5
  load_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> outValid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)
                                 && $stable(outSop) && $stable(outEop)));

endmodule

// File: rtl/frame_head_sel.sv
module frame_head_sel
  import hsel_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int KEEP_WORDS = 4,
  parameter bit COMPLEX_IN = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   inData,
  input  logic [DATA_W/2-1:0] inRe,
  input  logic [DATA_W/2-1:0] inIm,
  input  logic                inValid,
  input  logic                inSop,
  input  logic                inEop,
  output logic                inReady,
  output logic [DATA_W-1:0]   outData,
  output logic                outValid,
  output logic                outSop,
  output logic                outEop,
  input  logic                outReady
);

  hselStrobe_t       strobe;
  logic [DATA_W-1:0] word;
  logic              slotFree;

  hsel_word_pack #(.DATA_W(DATA_W), .COMPLEX_IN(COMPLEX_IN)) pack_i (
    .plainData(inData),
    .reData   (inRe),
    .imData   (inIm),
    .word     (word)
  );

  hsel_ctrl #(.KEEP_WORDS(KEEP_WORDS)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inSop   (inSop),
    .inEop   (inEop),
    .slotFree(slotFree),
    .inReady (inReady),
    .strobe  (strobe)
  );

  hsel_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .word    (word),
    .outReady(outReady),
    .outData (outData),
    .outValid(outValid),
    .outSop  (outSop),
    .outEop  (outEop),
    .slotFree(slotFree)
  );

  // R7
  empty_slot_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> inReady);

  // R3
  sop_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outEop) |=> (!outValid || outSop));

endmodule

// File: tb/frame_head_sel_tb_top.sv
module frame_head_sel_tb_top;

  localparam int W = 16;
  localparam int N = 4;

  typedef struct packed {
    logic [W-1:0] d;
    logic         s;
    logic         e;
  } expWord_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst;

  logic [W/2-1:0] zeroHalf = '0;
  logic [W-1:0]   zeroWord = '0;

  // dut_i: plain words, KEEP_WORDS=4
  logic [W-1:0] aData, aOutData;
  logic aValid, aSop, aEop, aReady, aOutValid, aOutSop, aOutEop, aOutReady;
  // dutOne_i: complex words, KEEP_WORDS=1
  logic [W/2-1:0] bRe, bIm;
  logic [W-1:0]   bOutData;
  logic bValid, bSop, bEop, bReady, bOutValid, bOutSop, bOutEop, bOutReady;

  frame_head_sel #(.DATA_W(W), .KEEP_WORDS(N), .COMPLEX_IN(1'b0)) dut_i (
    .clk(clk), .rst(rst), .inData(aData), .inRe(zeroHalf), .inIm(zeroHalf),
    .inValid(aValid), .inSop(aSop), .inEop(aEop), .inReady(aReady),
    .outData(aOutData), .outValid(aOutValid), .outSop(aOutSop), .outEop(aOutEop),
    .outReady(aOutReady));

  frame_head_sel #(.DATA_W(W), .KEEP_WORDS(1), .COMPLEX_IN(1'b1)) dutOne_i (
    .clk(clk), .rst(rst), .inData(zeroWord), .inRe(bRe), .inIm(bIm),
    .inValid(bValid), .inSop(bSop), .inEop(bEop), .inReady(bReady),
    .outData(bOutData), .outValid(bOutValid), .outSop(bOutSop), .outEop(bOutEop),
    .outReady(bOutReady));

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  expWord_t q[$];
  int  mCnt = 0;
  int  framePos = 0;
  int  frameLen = 3;
  bit  lastAcc = 0;
  bit  expValid = 0;
  bit  holdPending = 0;
  logic [W-1:0] holdData;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected output entry for an accepted input word; returns 0 when dropped
  function automatic bit modelAccept(logic [W-1:0] d, logic s, logic e,
                                     output expWord_t x);
    int idx;
    idx = s ? 0 : mCnt;
    x.d = d;
    x.s = (idx == 0);
    x.e = (idx == N - 1) || e;
    mCnt = e ? 0 : ((idx < N) ? idx + 1 : N);
    return (idx < N);
  endfunction

  task automatic cycleA(int validPct, int readyPct, bit gapless);
    expWord_t x;
    expWord_t got;
    @(negedge clk);
    if (lastAcc) aValid = 1'b0;
    lastAcc = 0;
    if (!aValid && ($urandom_range(99) < validPct)) begin
      aValid = 1'b1;
      aSop   = (framePos == 0);
      aEop   = (framePos == frameLen - 1);
      aData  = W'($urandom);
    end
    aOutReady = ($urandom_range(99) < readyPct);
    #3;
    if (expValid) chk(aOutValid, "R5", "outValid after forward", int'(aOutValid), 1);
    if (holdPending) begin
      chk(aOutValid, "R8", "outValid held", int'(aOutValid), 1);
      chk(aOutData == holdData, "R8", "outData held", int'(aOutData), int'(holdData));
    end
    expValid = 0;
    holdPending = aOutValid && !aOutReady;
    holdData = aOutData;
    if (gapless && aValid) chk(aReady, "R7", "gapless ready", int'(aReady), 1);
    if (aValid && mCnt >= N && !aSop)
      chk(aReady, "R6", "ready in discard", int'(aReady), 1);
    if (aOutValid && aOutReady) begin
      if (q.size() == 0) chk(1'b0, "R2", "unexpected output word", int'(aOutData), 0);
      else begin
        got = q.pop_front();
        chk(aOutData == got.d, "R1", "data", int'(aOutData), int'(got.d));
        chk(aOutSop == got.s, "R3", "sop", int'(aOutSop), int'(got.s));
        chk(aOutEop == got.e, "R4", "eop", int'(aOutEop), int'(got.e));
      end
    end
    if (aValid && aReady) begin
      if (modelAccept(aData, aSop, aEop, x)) begin
        q.push_back(x);
        expValid = 1;
      end
      lastAcc = 1;
      framePos++;
      if (aEop) begin
        framePos = 0;
        frameLen = $urandom_range(10, 1);
      end
    end
  endtask

  task automatic driveB(bit v, logic [W/2-1:0] re, logic [W/2-1:0] im,
                        bit s, bit e, bit rdy);
    @(negedge clk);
    bValid = v; bRe = re; bIm = im; bSop = s; bEop = e; bOutReady = rdy;
    #3;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    aValid = 0; aSop = 0; aEop = 0; aData = '0; aOutReady = 0;
    bValid = 0; bSop = 0; bEop = 0; bRe = '0; bIm = '0; bOutReady = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #3;
    // R10: reset state
    chk(!aOutValid, "R10", "outValid after reset", int'(aOutValid), 0);
    chk(aReady, "R10", "inReady after reset", int'(aReady), 1);
    chk(!bOutValid, "R10", "N=1 outValid after reset", int'(bOutValid), 0);

    // R7: gapless stream, always-ready sink
    repeat (300) cycleA(100, 100, 1'b1);
    // mixed random traffic
    repeat (1500) cycleA(70, 60, 1'b0);
    repeat (1500) cycleA(100, 40, 1'b0);
    repeat (1500) cycleA(40, 100, 1'b0);
    // drain
    repeat (40) cycleA(0, 100, 1'b0);
    chk(q.size() == 0, "R2", "all expected words seen", q.size(), 0);

    // R10: reset while an output word is stalled
    @(negedge clk);
    aValid = 1; aSop = 1; aEop = 0; aData = 16'hBEEF; aOutReady = 0;
    @(negedge clk);
    aValid = 0;
    #3;
    chk(aOutValid, "R10", "word pending before reset", int'(aOutValid), 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #3;
    chk(!aOutValid, "R10", "outValid cleared by reset", int'(aOutValid), 0);
    chk(aReady, "R10", "inReady after mid-run reset", int'(aReady), 1);
    q.delete(); mCnt = 0; framePos = 0; frameLen = 3;
    lastAcc = 0; expValid = 0; holdPending = 0;
    repeat (400) cycleA(80, 70, 1'b0);
    repeat (40) cycleA(0, 100, 1'b0);
    chk(q.size() == 0, "R2", "all words seen after reset", q.size(), 0);

    // R9 / R11: KEEP_WORDS=1 with complex packing
    driveB(1, 8'h12, 8'h34, 1, 0, 1);
    chk(bReady, "R11", "ready for first word", int'(bReady), 1);
    driveB(1, 8'h56, 8'h78, 0, 0, 0);
    chk(bOutValid, "R11", "single word out", int'(bOutValid), 1);
    chk(bOutData == 16'h1234, "R9", "complex packing", int'(bOutData), 16'h1234);
    chk(bOutSop && bOutEop, "R11", "sop and eop together",
        int'({bOutSop, bOutEop}), 3);
    chk(bReady, "R6", "discard ready under stall", int'(bReady), 1);
    driveB(1, 8'h9A, 8'hBC, 0, 1, 0);
    chk(bReady, "R6", "discard ready at eop", int'(bReady), 1);
    chk(bOutValid && bOutData == 16'h1234, "R8", "N=1 stalled word held",
        int'(bOutData), 16'h1234);
    driveB(1, 8'hDE, 8'hF0, 1, 1, 1);
    chk(bReady, "R7", "ready when sink frees", int'(bReady), 1);
    driveB(0, 8'h00, 8'h00, 0, 0, 1);
    chk(bOutValid && bOutData == 16'hDEF0, "R9", "second complex word",
        int'(bOutData), 16'hDEF0);
    chk(bOutSop && bOutEop, "R11", "one-word frame flags",
        int'({bOutSop, bOutEop}), 3);
    driveB(0, 8'h00, 8'h00, 0, 0, 1);
    chk(!bOutValid, "R2", "dropped words stay dropped", int'(bOutValid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule